// File: doc/BRIEF.md
# Circular Return-Address and Data Stack

This block is a small on-chip last-in, first-out store of sixteen 16-bit words. A processor core keeps subroutine return addresses and spilled data in it. The core's call and interrupt-entry sequences reach it only as push requests, and its return sequences reach it only as pop requests. The block itself knows nothing about instructions.

The pointer comes out of reset on the highest entry. A push first advances the pointer and then writes the incoming word at the new location. The word at the current pointer is always visible on the read port. A pop therefore has its data in the same cycle it is requested, and the pointer steps back on the following clock edge. The pointer is four bits wide and simply wraps in both directions. No fullness or emptiness is tracked, so a seventeenth push overwrites the oldest word. The contents are not cleared by reset.

Top module: `ret_stack`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `sp_o` equals 4'hF.
- R2: A push advances `sp_o` by one at the clock edge and stores `push_data_i` at the new pointer value, so `top_data_o` shows that word from the next cycle on.
- R3: `top_data_o` always presents the word stored at the current `sp_o`. A pop request therefore sees the popped word in the same cycle it is raised, and `sp_o` drops by one at the following clock edge.
- R4: A push with `sp_o` at 4'hF moves the pointer to 4'h0 and writes entry 0.
- R5: A pop with `sp_o` at 4'h0 moves the pointer to 4'hF.
- R6: When push and pop are requested in the same cycle, only the push takes effect.
- R7: With neither request raised, `sp_o` and the stored words stay unchanged.
- R8: After more than sixteen consecutive pushes, the oldest words are overwritten in place and no error or status is produced.
- R9: Reset does not alter the stored words. After reset, `top_data_o` shows whatever was last written to entry 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | 16 | Word to be stored by a push |
| top_data_o | output | 16 | Word at the current pointer (pop data) |
| sp_o | output | 4 | Current stack pointer |

## Verification
A pointer that steps wrongly shows on `sp_o` one clock after the offending request. From then on, every later read of `top_data_o` follows the wrong entry. A write that lands on the wrong entry does not show at once. It appears only when the pointer later returns to that entry, which can take up to fifteen pops or a full wrap of pushes. For that reason the stimulus walks the pointer back and forth through all sixteen entries many times and compares every visible word against a model.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    // Request decoded for one cycle; push has priority over pop.
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    function automatic stk_op_e stk_decode(input logic push, input logic pop);
        if (push)     return STK_PUSH;
        else if (pop) return STK_POP;
        else          return STK_IDLE;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import ret_stack_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] sp_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o
);

    localparam logic [PTR_W-1:0] TOP_IDX = '1;
    localparam logic [PTR_W-1:0] BOT_IDX = '0;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    stk_op_e    op;
    logic [PTR_W-1:0] sp_inc, sp_dec;

    always_comb begin
        op        = stk_decode(push_i, pop_i);
        sp_inc    = PTR_W'(st_q.sp + 1'b1);
        sp_dec    = PTR_W'(st_q.sp - 1'b1);
        st_d      = st_q;
        wr_en_o   = 1'b0;
        wr_addr_o = sp_inc;
        case (op)
            STK_PUSH: begin
                st_d.sp = sp_inc;
                wr_en_o = 1'b1;
            end
            STK_POP: begin
                st_d.sp = sp_dec;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sp <= TOP_IDX;
        else        st_q    <= st_d;
    end

    assign sp_o = st_q.sp;

    // R1: pointer sits on the top entry right after reset
    p_reset_top_r1: assert property (@(posedge clk)
        !rst_n |=> (st_q.sp == TOP_IDX));

    // R2: push advances pointer by one
    p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (st_q.sp == PTR_W'($past(st_q.sp) + 1'b1)));

    // R3 / R6: pop alone retreats by one
    p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (st_q.sp == PTR_W'($past(st_q.sp) - 1'b1)));

    // R4: wrap upward
    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && st_q.sp == TOP_IDX) |=> (st_q.sp == BOT_IDX));

    // R5: wrap downward
    p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.sp == BOT_IDX) |=> (st_q.sp == TOP_IDX));

    // R7: idle holds pointer
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(st_q.sp));

endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << PTR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we_i && waddr_i == PTR_W'(i)) st_d.ent[i] = wdata_i;
        end
    end

    // contents deliberately not reset (R9)
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata_o = st_q.ent[raddr_i];

    // R2: a write lands at the addressed entry
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (st_q.ent[$past(waddr_i)] == $past(wdata_i)));

    // R7: without a write every entry keeps its value
    p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(st_q));

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] top_data_o,
    output logic [PTR_W-1:0]  sp_o
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] sp_q;

    stk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .sp_o      (sp_q),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr)
    );

    stk_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (push_data_i),
        .raddr_i (sp_q),
        .rdata_o (top_data_o)
    );

    assign sp_o = sp_q;

    // R6: a combined request writes, which only a push does
    p_both_is_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (top_data_o == $past(push_data_i)));

endmodule

// File: tb/ret_stack_bench.sv
`timescale 1ns/1ps
module ret_stack_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] top_data;
    logic [3:0]  sp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] mdl_mem [16];
    bit          mdl_vld [16];
    logic [3:0]  mdl_sp;

    always #5 clk = ~clk;

    ret_stack u_ret_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (wdata),
        .top_data_o  (top_data),
        .sp_o        (sp)
    );

    function automatic logic [3:0] next_sp(input logic [3:0] cur, input bit p, input bit q);
        if (p)      return 4'(cur + 1'b1);
        else if (q) return 4'(cur - 1'b1);
        else        return cur;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, {12'd0, sp}, {12'd0, mdl_sp});
        if (mdl_vld[mdl_sp]) chk(req, top_data, mdl_mem[mdl_sp]);
    endtask

    task automatic step(input bit p, input bit q, input logic [15:0] d, input string req);
        @(negedge clk);
        push = p; pop = q; wdata = d;
        #1;
        // R3: pop data visible in the request cycle
        if (q && !p && mdl_vld[mdl_sp]) chk("R3", top_data, mdl_mem[mdl_sp]);
        @(posedge clk);
        #1;
        mdl_sp = next_sp(mdl_sp, p, q);
        if (p) begin
            mdl_mem[mdl_sp] = d;
            mdl_vld[mdl_sp] = 1'b1;
        end
        chk_state(req);
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        mdl_sp = 4'hF;
        chk("R1", {12'd0, sp}, 16'h000F);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", {12'd0, sp}, 16'h000F);
        // R9: entry F keeps its old contents across reset
        if (mdl_vld[15]) chk("R9", top_data, mdl_mem[15]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl_vld[i] = 1'b0;
        mdl_sp = 4'hF;
        void'($urandom(32'd20240611));
        do_reset();

        // R2, R4: first push wraps F -> 0
        step(1'b1, 1'b0, 16'hA5A5, "R4");
        step(1'b1, 1'b0, 16'h1234, "R2");
        // R7: idle cycles
        step(1'b0, 1'b0, 16'hFFFF, "R7");
        step(1'b0, 1'b0, 16'h0BAD, "R7");
        // R6: both requests act as push
        step(1'b1, 1'b1, 16'hC0DE, "R6");
        step(1'b0, 1'b1, 16'h0000, "R3");
        step(1'b0, 1'b1, 16'h0000, "R3");
        step(1'b0, 1'b1, 16'h0000, "R5");   // sp 0 -> F
        // R8: fill all 16 entries plus one, oldest overwritten
        for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 16'(16'h4000 + i), "R8");
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 16'h0000, "R8");
        // R9: reset retains contents
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 16'(16'h7700 + i), "R2");
        do_reset();
        step(1'b0, 1'b1, 16'h0000, "R9");

        // constrained random mix
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom % 8);
            bit p = (r < 3) || (r == 7);
            bit q = (r >= 3 && r < 6) || (r == 7);
            string tag = (p && q) ? "R6" : p ? "R2" : q ? "R3" : "R7";
            step(p, q, 16'($urandom), tag);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule